// File: doc/BRIEF.md
# Staged Crosspoint Routing Controller

This block is the control side of an eight-source by four-destination routing matrix. A host writes one routing entry at a time over a parallel bus with a select and a write strobe. Each entry goes into a staging register for the addressed destination. The active routing does not change until the host raises a separate commit strobe. That strobe copies all four staged entries into the active set on one clock edge, so a new routing pattern takes effect in a single step.

The active entries drive a 32-bit switch-enable vector, in groups of eight bits per destination. They also drive one disable flag per destination, which external logic uses to put a downstream buffer into a low-power state. The host can read an active entry back by addressing its destination with the select asserted and the strobe low.

Top module: `xbar_route_ctrl`

## Requirements
- R1: An entry is 4 bits. Bits [2:0] pick the source (0..7). Bit 3 set means the destination is enabled.
- R2: While `rst` is high, all staged and active entries clear to 4'b0000. On the first clock after reset, all disable flags read 1 and the switch vector reads 0.
- R3: A staged entry is written only on a clock edge where `sel` and `wr` are both high. The value on `wdata` goes to the destination given by `dest`.
- R4: Writing a staged entry leaves the switch vector, the disable flags and the readback unchanged until a commit.
- R5: On a clock edge where `commit` is high, all four active entries take their staged values.
- R6: If a commit and a write to the same destination fall on the same edge, the active entry receives the old staged value. The staged register receives the new value.
- R7: Bits [8*d+7 : 8*d] of `sw_en` belong to destination d. For an enabled destination, exactly the bit for its source is high. For a disabled destination, all eight bits are low.
- R8: `dis[d]` is the inverse of bit 3 of active entry d.
- R9: A read cycle has `sel` high and `wr` low. One clock later, `rdata` holds the active entry of the addressed destination and `rvalid` is high. At all other times `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus select |
| wr | input | 1 | Write strobe |
| dest | input | 2 | Destination address |
| wdata | input | 4 | Entry to stage |
| commit | input | 1 | Copy staged entries to active |
| rdata | output | 4 | Readback of an active entry |
| rvalid | output | 1 | Readback valid |
| sw_en | output | 32 | Crosspoint switch enables |
| dis | output | 4 | Per-destination disable flags |

## Verification
The bench first routes a single source to all four destinations. This shows that one source can feed several outputs and that the outputs are decoded independently. It then steps through every source code on each destination, which separates the position of each enable bit from its neighbours.

A series of writes with no commit shows that staging does not leak into the outputs. A commit on the same edge as a write to the same destination separates the old staged value from the new one. Mixed enabled and disabled entries exercise the disable flags and the blanking of the switch groups. A randomized phase compares a behavioural model against the design on every clock.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int N_SRC  = 8;
    localparam int N_DST  = 4;
    localparam int SRC_W  = $clog2(N_SRC);
    localparam int DST_W  = $clog2(N_DST);
    localparam int ENT_W  = SRC_W + 1;
    localparam int SW_W   = N_SRC * N_DST;

    typedef struct packed {
        logic             on;
        logic [SRC_W-1:0] src;
    } route_t;

    localparam route_t ROUTE_OFF = '{on: 1'b0, src: '0};

    function automatic logic [N_SRC-1:0] route_decode(route_t r);
        logic [N_SRC-1:0] v;
        v = '0;
        if (r.on) v[r.src] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/xbar_stage_bank.sv
module xbar_stage_bank
    import xbar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DST_W-1:0] waddr,
    input  route_t           wentry,
    output route_t           staged [N_DST]
);
    for (genvar d = 0; d < N_DST; d++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) staged[d] <= ROUTE_OFF;
            else if (we && waddr == DST_W'(d)) staged[d] <= wentry;
        end
    end
endmodule

// File: rtl/xbar_active_bank.sv
module xbar_active_bank
    import xbar_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  route_t staged [N_DST],
    output route_t active [N_DST]
);
    for (genvar d = 0; d < N_DST; d++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst) active[d] <= ROUTE_OFF;
            else if (load) active[d] <= staged[d];
        end
    end
endmodule

// File: rtl/xbar_decode.sv
module xbar_decode
    import xbar_pkg::*;
(
    input  route_t            active [N_DST],
    output logic [SW_W-1:0]   sw_en,
    output logic [N_DST-1:0]  dis
);
    for (genvar d = 0; d < N_DST; d++) begin : g_dec
        assign sw_en[d*N_SRC +: N_SRC] = route_decode(active[d]);
        assign dis[d] = ~active[d].on;
    end
endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
    import xbar_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr,
    input  logic [1:0]       dest,
    input  logic [3:0]       wdata,
    input  logic             commit,
    output logic [3:0]       rdata,
    output logic             rvalid,
    output logic [31:0]      sw_en,
    output logic [3:0]       dis
);
    route_t staged [N_DST];
    route_t active [N_DST];

    xbar_stage_bank u_stage (
        .clk(clk), .rst(rst), .we(sel && wr), .waddr(dest),
        .wentry(route_t'(wdata)), .staged(staged)
    );

    xbar_active_bank u_active (
        .clk(clk), .rst(rst), .load(commit), .staged(staged), .active(active)
    );

    xbar_decode u_dec (.active(active), .sw_en(sw_en), .dis(dis));

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= sel && !wr;
            if (sel && !wr) rdata <= active[dest];
        end
    end
endmodule

// File: rtl/xbar_route_ctrl_chk.sv
module xbar_route_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        sel,
    input logic        wr,
    input logic        commit,
    input logic [31:0] sw_en,
    input logic [3:0]  dis,
    input logic        rvalid
);
    // R7
    for (genvar d = 0; d < 4; d++) begin : g_c
        always_ff @(posedge clk) begin
            if (!rst) begin
                grp_onehot_chk: assert ($onehot0(sw_en[d*8 +: 8]))
                    else $error("R7 group %0d not onehot0", d);
                // R8
                dis_match_chk: assert (dis[d] == (sw_en[d*8 +: 8] == 8'd0))
                    else $error("R8 dis mismatch %0d", d);
            end
        end
    end

    // R2
    reset_dis_chk: assert property (@(posedge clk) rst |=> (dis == 4'hF && sw_en == '0));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(sw_en));

    // R9
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr) |=> rvalid);

    // R9
    rvalid_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr) |=> !rvalid);
endmodule

bind xbar_route_ctrl xbar_route_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .commit(commit),
    .sw_en(sw_en), .dis(dis), .rvalid(rvalid)
);

// File: tb/xbar_route_ctrl_test.sv
module xbar_route_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, sel = 0, wr = 0, commit = 0;
    logic [1:0] dest = 0;
    logic [3:0] wdata = 0;
    logic [3:0] rdata;
    logic rvalid;
    logic [31:0] sw_en;
    logic [3:0] dis;

    int checks = 0, errors = 0;
    int m_stage [4];
    int m_act [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_route_ctrl uut (.*);

    function automatic logic [31:0] exp_sw();
        logic [31:0] v = 0;
        for (int d = 0; d < 4; d++)
            if (m_act[d] >= 8) v[d*8 + (m_act[d] % 8)] = 1'b1;
        return v;
    endfunction

    function automatic logic [3:0] exp_dis();
        logic [3:0] v;
        for (int d = 0; d < 4; d++) v[d] = (m_act[d] < 8);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: apply inputs, update model at edge, check outputs after
    task automatic cyc(logic s, logic w, logic [1:0] a, logic [3:0] dt, logic c);
        bit rd;
        int rexp;
        sel = s; wr = w; dest = a; wdata = dt; commit = c;
        rd = s && !w;
        rexp = m_act[a];
        @(posedge clk);
        if (c) for (int d = 0; d < 4; d++) m_act[d] = m_stage[d];
        if (s && w) m_stage[a] = dt;
        #1;
        chk("R7", sw_en, exp_sw());
        chk("R8", {28'd0, dis}, {28'd0, exp_dis()});
        chk("R9", {31'd0, rvalid}, {31'd0, rd});
        if (rd) chk("R9", {28'd0, rdata}, rexp);
        sel = 0; wr = 0; commit = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int d = 0; d < 4; d++) begin m_stage[d] = 0; m_act[d] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R2 reset state
        chk("R2", sw_en, 0);
        chk("R2", {28'd0, dis}, 32'hF);
        rst = 0;
        // R1 R3 R4: broadcast source 5 to all destinations, no commit
        for (int d = 0; d < 4; d++) cyc(1, 1, 2'(d), 4'hD, 0);
        chk("R4", sw_en, 0);
        // readback still old
        for (int d = 0; d < 4; d++) cyc(1, 0, 2'(d), 0, 0);
        // R5 commit
        cyc(0, 0, 0, 0, 1);
        chk("R5", sw_en, 32'h20202020);
        // walk every source on each destination
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 8; s++) begin
                cyc(1, 1, 2'(d), 4'(8 + s), 0);
                cyc(0, 0, 0, 0, 1);
                cyc(1, 0, 2'(d), 0, 0);
            end
        // R8 disable mix
        cyc(1, 1, 1, 4'h3, 0);
        cyc(1, 1, 3, 4'h7, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R8", {28'd0, dis}, 32'hA);
        // R6 collision: stage 9 on dest 2, then commit with write A
        cyc(1, 1, 2, 4'h9, 0);
        cyc(1, 1, 2, 4'hA, 1);
        chk("R6", {24'd0, sw_en[23:16]}, 32'h02);
        cyc(0, 0, 0, 0, 1);
        chk("R6", {24'd0, sw_en[23:16]}, 32'h04);
        // R3: strobe without select ignored
        sel = 0; wr = 1; dest = 0; wdata = 4'hF;
        @(posedge clk); #1; wr = 0;
        cyc(0, 0, 0, 0, 1);
        chk("R3", {24'd0, sw_en[7:0]}, {24'd0, exp_sw()[7:0]});
        // randomized
        for (int i = 0; i < 2000; i++)
            cyc(1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom % 4 == 0));
        // R2 reset mid-run
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int d = 0; d < 4; d++) begin m_stage[d] = 0; m_act[d] = 0; end
        chk("R2", {28'd0, dis}, 32'hF);
        cyc(0, 0, 0, 0, 1);
        chk("R2", sw_en, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule